// File: doc/BRIEF.md
# Row/Column DRAM Access Controller with Self-Timed Refresh

This block connects a requester that issues whole byte addresses to a DRAM device whose address pins are shared between row and column. A 21-bit request address is divided into a 12-bit row taken from the upper bits and a 9-bit column taken from the lower bits. The controller opens the row with the row strobe, waits a fixed activation time, and then issues one column strobe per data beat. It advances the column by itself, so a single request returns a burst of 1, 2, 4 or 8 consecutive bytes from the open row.

Requests enter through a valid/ready handshake. The requester raises `req_valid` with the address, direction, write byte and burst mode, and holds all of them steady until it sees `req_ready` high at a clock edge. The controller captures every field at that edge. Returned bytes carry no back-pressure: each one shows up as a single-cycle `rd_valid` pulse, and the requester has to take it in that cycle. A timer inside the block spreads row refreshes evenly over the retention period. When a refresh is due it wins over any waiting request.

Top module: `dram_rowcol_ctrl`

## Requirements
- R1: After reset `dram_ras`, `dram_cas`, `dram_we` and `rd_valid` are low and `req_ready` is high.
- R2: While the row strobe is high without the column strobe, `dram_addr` carries the row `req_addr[20:9]` and stays constant.
- R3: `dram_ras` rises in the cycle after the accepting edge. The first `dram_cas` comes exactly three cycles after that, which leaves two activation cycles between row and column.
- R4: `rd_valid` is high in the cycle after each read column strobe, and `rd_data` then holds the device byte at the open row and the strobed column.
- R5: `req_mode` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 bytes. The bytes arrive in consecutive cycles, with `dram_cas` high in each beat and the column on `dram_addr[8:0]` (upper lines zero) going up by one per beat.
- R6: The burst column wraps from 511 to 0 inside the same row.
- R7: A write (`req_write`=1) issues exactly one column strobe with `dram_we` high and `dram_wdata` equal to the captured byte. It produces no `rd_valid`, and `req_mode` has no effect on it.
- R8: `req_ready` is high only when the controller is idle and no refresh is pending. The request fields are captured at the accepting edge, and later changes to them have no effect on the access in progress.
- R9: A refresh starts every CLK_MHZ*64000/4096 cycles (1562 at 100 MHz) when the controller is idle. It holds `dram_ras` high for 3 cycles with no column strobe.
- R10: Each refresh drives the next row number on `dram_addr`, one above the previous refresh row, modulo 4096.
- R11: A pending refresh is served before a waiting request, and `req_ready` stays low while a refresh is pending or running.
- R12: `dram_cas` is high only while `dram_ras` is high, and `dram_ras` stays low for at least one precharge cycle between two row openings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_addr | input | 21 | Byte address, row in upper 12 bits |
| req_write | input | 1 | 1 = write one byte, 0 = burst read |
| req_wdata | input | 8 | Write byte |
| req_mode | input | 2 | Read burst length select (1, 2, 4, 8) |
| rd_valid | output | 1 | One-cycle pulse per returned byte |
| rd_data | output | 8 | Returned byte |
| dram_addr | output | 12 | Shared row/column address lines |
| dram_ras | output | 1 | Row strobe, high while row open |
| dram_cas | output | 1 | Column strobe, one per beat |
| dram_we | output | 1 | Write enable with column strobe |
| dram_wdata | output | 8 | Byte to device |
| dram_rdata | input | 8 | Byte from device, valid the cycle after a read strobe |

## Verification
The bench follows every access cycle by cycle from the accepting edge. A design that is off by one in activation time would put the column strobe or the first byte a cycle early or late. A read starting at column 510 checks that the column wraps to 0 and that the row stays the same; a controller that carried into the row would return bytes from the next row. A request raised in the single cycle when a refresh is pending must wait exactly five cycles. If requests had priority, that request would open its row and the refresh would slip. Refresh spacing and row stepping are measured on an idle bus, and a write issued with the 8-beat mode must still produce exactly one strobe.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_CAS,
    ST_PRE,
    ST_REF
  } ctrl_state_e;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int INTERVAL = 1562,
  parameter int ROW_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  output logic             pending,
  output logic [ROW_W-1:0] row
);
  localparam int CNT_W = $clog2(INTERVAL);

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick = (cnt == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + CNT_W'(1);
      if (tick)       pending <= 1'b1;
      else if (start) pending <= 1'b0;
      if (done) row <= row + ROW_W'(1);
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 9,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COL_W-1:0]  col_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              step,
  output logic [COL_W-1:0]  col,
  output logic              last
);
  // beats up to 2**(2**MODE_W - 1) fit in 2**MODE_W bits
  localparam int CNT_W = (1 << MODE_W);

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col  <= '0;
      left <= '0;
    end else if (load) begin
      col  <= col_in;
      left <= CNT_W'(1) << mode_in;
    end else if (step) begin
      col  <= col + COL_W'(1);
      left <= left - CNT_W'(1);
    end
  end

  assign last = (left == CNT_W'(1));
endmodule

// File: rtl/dram_rowcol_ctrl.sv
module dram_rowcol_ctrl #(
  parameter int ROW_W         = 12,
  parameter int COL_W         = 9,
  parameter int DATA_W        = 8,
  parameter int MODE_W        = 2,
  parameter int ACT_WAIT      = 2,
  parameter int CLK_MHZ       = 100,
  parameter int REF_PERIOD_US = 64000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [MODE_W-1:0]        req_mode,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic [ROW_W-1:0]         dram_addr,
  output logic                     dram_ras,
  output logic                     dram_cas,
  output logic                     dram_we,
  output logic [DATA_W-1:0]        dram_wdata,
  input  logic [DATA_W-1:0]        dram_rdata
);
  import dram_ctrl_pkg::*;

  localparam int ADDR_W       = ROW_W + COL_W;
  localparam int ROWS         = 1 << ROW_W;
  localparam int REF_INTERVAL = CLK_MHZ * REF_PERIOD_US / ROWS;
  localparam int REF_HOLD     = ACT_WAIT + 1;
  localparam int WAIT_W       = $clog2(REF_HOLD + 1);

  ctrl_state_e        state;
  logic [ROW_W-1:0]   row_q;
  logic               we_q;
  logic [DATA_W-1:0]  wd_q;
  logic [WAIT_W-1:0]  wcnt;
  logic               rdv_q;

  logic               ref_pend, ref_start, ref_done;
  logic [ROW_W-1:0]   ref_row;
  logic               accept;
  logic [COL_W-1:0]   col;
  logic               col_last;

  assign accept    = (state == ST_IDLE) && !ref_pend && req_valid;
  assign ref_start = (state == ST_IDLE) && ref_pend;
  assign ref_done  = (state == ST_REF) && (wcnt == WAIT_W'(REF_HOLD - 1));

  refresh_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .start(ref_start), .done(ref_done),
    .pending(ref_pend), .row(ref_row)
  );

  burst_col_gen #(.COL_W(COL_W), .MODE_W(MODE_W)) u_col (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .col_in(req_addr[COL_W-1:0]),
    .mode_in(req_write ? '0 : req_mode),
    .step(state == ST_CAS), .col(col), .last(col_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row_q <= '0;
      we_q  <= 1'b0;
      wd_q  <= '0;
      wcnt  <= '0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= (state == ST_CAS) && !we_q;
      case (state)
        ST_IDLE: begin
          wcnt <= '0;
          if (ref_pend) begin
            state <= ST_REF;
          end else if (req_valid) begin
            state <= ST_ACT;
            row_q <= req_addr[ADDR_W-1:COL_W];
            we_q  <= req_write;
            wd_q  <= req_wdata;
          end
        end
        ST_ACT: begin
          state <= ST_RCD;
          wcnt  <= '0;
        end
        ST_RCD: begin
          if (wcnt == WAIT_W'(ACT_WAIT - 1)) state <= ST_CAS;
          else wcnt <= wcnt + WAIT_W'(1);
        end
        ST_CAS: if (col_last) state <= ST_PRE;
        ST_PRE: state <= ST_IDLE;
        ST_REF: begin
          if (ref_done) state <= ST_PRE;
          else wcnt <= wcnt + WAIT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE) && !ref_pend;
  assign dram_ras   = (state == ST_ACT) || (state == ST_RCD) ||
                      (state == ST_CAS) || (state == ST_REF);
  assign dram_cas   = (state == ST_CAS);
  assign dram_we    = (state == ST_CAS) && we_q;
  assign dram_wdata = wd_q;
  assign dram_addr  = (state == ST_CAS) ? {{(ROW_W-COL_W){1'b0}}, col} :
                      (state == ST_REF) ? ref_row : row_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = dram_rdata;
endmodule

// File: rtl/dram_ctrl_checker.sv
module dram_ctrl_checker #(
  parameter int ROW_W = 12,
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rd_valid,
  input logic [ROW_W-1:0] dram_addr,
  input logic             dram_ras,
  input logic             dram_cas,
  input logic             dram_we
);
  // R12: column strobe only inside an open row
  p_cas_in_row_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dram_cas |-> dram_ras);

  // R12: a closing row gets at least one precharge cycle
  p_precharge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras) |=> !dram_ras);

  // R11: no acceptance while a row or refresh is active
  p_ready_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dram_ras |-> !req_ready);

  // R3: acceptance opens a row in the next cycle
  p_accept_opens_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (dram_ras && !dram_cas));

  // R2: row address stays put during activation
  p_row_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras && $past(dram_ras) && !dram_cas && !$past(dram_cas)) |-> $stable(dram_addr));

  // R5: column advances by one on back-to-back strobes
  p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas && $past(dram_cas)) |->
      (dram_addr[COL_W-1:0] == COL_W'($past(dram_addr[COL_W-1:0]) + COL_W'(1))));

  // R4: returned byte follows a read strobe
  p_rdv_follows_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(dram_cas && !dram_we));

  // R7: write enable only with a column strobe
  p_we_with_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dram_we |-> dram_cas);
endmodule

bind dram_rowcol_ctrl dram_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .dram_addr(dram_addr), .dram_ras(dram_ras),
  .dram_cas(dram_cas), .dram_we(dram_we)
);

// File: tb/tb_dram_rowcol_ctrl.sv
`timescale 1ns/1ps
module tb_dram_rowcol_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [1:0]  req_mode = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [11:0] dram_addr;
  logic        dram_ras, dram_cas, dram_we;
  logic [7:0]  dram_wdata;
  logic [7:0]  dram_rdata = '0;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dram_rowcol_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_mode(req_mode), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras(dram_ras), .dram_cas(dram_cas),
    .dram_we(dram_we), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  // ---------------- device model ----------------
  logic [7:0] wmem [int];
  logic [11:0] m_row = '0;
  bit          m_ras_d = 1'b0;

  function automatic logic [7:0] dev_read(logic [11:0] r, logic [8:0] c);
    int key = int'({r, c});
    if (wmem.exists(key)) return wmem[key];
    return r[7:0] ^ {c[6:0], c[8]} ^ 8'h3C ^ {4'h0, r[11:8]};
  endfunction

  always @(posedge clk) begin
    if (dram_ras && !m_ras_d) m_row = dram_addr;
    if (dram_cas) begin
      if (dram_we) wmem[int'({m_row, dram_addr[8:0]})] = dram_wdata;
      else dram_rdata <= dev_read(m_row, dram_addr[8:0]);
    end
    m_ras_d = dram_ras;
  end

  // ---------------- row-open monitor ----------------
  int cyc = 0;
  bit open_f = 1'b0;
  bit saw_cas = 1'b0;
  int open_start = 0;
  logic [11:0] open_row = '0;
  int ref_cnt = 0;
  int last_ref_start = 0, prev_ref_start = 0, last_ref_len = 0;
  logic [11:0] last_ref_row = '0, prev_ref_row = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (dram_ras && !open_f) begin
        open_f = 1'b1; open_start = cyc; saw_cas = 1'b0; open_row = dram_addr;
      end else if (open_f && dram_cas) begin
        saw_cas = 1'b1;
      end
      if (!dram_ras && open_f) begin
        open_f = 1'b0;
        if (!saw_cas) begin
          prev_ref_start = last_ref_start; last_ref_start = open_start;
          prev_ref_row = last_ref_row; last_ref_row = open_row;
          last_ref_len = cyc - open_start;
          ref_cnt++;
        end
      end
    end
    cyc++;
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [20:0] a, bit w, logic [7:0] wd, logic [1:0] m, output int waited);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd; req_mode = m;
    waited = 0;
    while (!req_ready) begin
      @(negedge clk);
      waited++;
    end
    @(posedge clk);
  endtask

  // follows one access from the accepting edge
  task automatic follow(logic [20:0] a, bit w, logic [7:0] wd, int n, string tag);
    logic [11:0] row = a[20:9];
    logic [8:0]  col = a[8:0];
    for (int k = 1; k <= n + 5; k++) begin
      bit er, ec, ev;
      @(negedge clk);
      er = (k <= 3 + n);
      ec = (k >= 4) && (k <= 3 + n);
      ev = !w && (k >= 5) && (k <= 4 + n);
      chk({dram_ras, dram_cas, rd_valid} == {er, ec, ev}, tag, "R3 R12 strobes",
          {dram_ras, dram_cas, rd_valid}, {er, ec, ev});
      if (er && !ec)
        chk(dram_addr == row, "R2", "row lines", dram_addr, row);
      if (ec) begin
        logic [8:0] cc = col + 9'(k - 4);
        chk(dram_addr == {3'b000, cc}, "R5", "column lines", dram_addr, {3'b000, cc});
        chk(dram_we == w, "R7", "write enable", dram_we, w);
        if (w) chk(dram_wdata == wd, "R7", "write byte", dram_wdata, wd);
      end
      if (ev) begin
        logic [8:0] dc = col + 9'(k - 5);
        chk(rd_data == dev_read(row, dc), "R4", "read byte", rd_data, dev_read(row, dc));
      end
      if (k == 1) begin  // R8: scramble fields after acceptance
        req_valid = 1'b0; req_addr = ~a; req_write = ~w; req_wdata = ~wd; req_mode = ~req_mode;
      end
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk({dram_ras, dram_cas, dram_we, rd_valid} == 4'b0, "R1", "strobes after reset",
        {dram_ras, dram_cas, dram_we, rd_valid}, 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
  endtask

  task automatic t_read(logic [20:0] a, logic [1:0] m, string tag);
    int w;
    issue(a, 1'b0, 8'h00, m, w);
    follow(a, 1'b0, 8'h00, 1 << m, tag);
  endtask

  task automatic t_write_back();
    int w;
    logic [20:0] a = {12'hABC, 9'h07F};
    issue(a, 1'b1, 8'hD5, 2'd3, w);   // R7: mode 3 must not lengthen a write
    follow(a, 1'b1, 8'hD5, 1, "R7");
    issue(a, 1'b0, 8'h00, 2'd0, w);
    follow(a, 1'b0, 8'h00, 1, "R7");
    chk(dev_read(12'hABC, 9'h07F) == 8'hD5, "R7", "stored byte", dev_read(12'hABC, 9'h07F), 8'hD5);
  endtask

  task automatic t_refresh();
    int r0 = ref_cnt;
    while (ref_cnt < r0 + 3) @(negedge clk);
    chk(last_ref_start - prev_ref_start == 100 * 64000 / 4096, "R9", "refresh spacing",
        last_ref_start - prev_ref_start, 100 * 64000 / 4096);
    chk(last_ref_len == 3, "R9", "refresh hold", last_ref_len, 3);
    chk(last_ref_row == prev_ref_row + 12'd1, "R10", "refresh row step",
        last_ref_row, prev_ref_row + 12'd1);
  endtask

  task automatic t_priority();
    int w, r0;
    logic [20:0] a = {12'h013, 9'h1F0};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    while (req_ready) @(negedge clk);   // now in the pending window
    r0 = ref_cnt;
    req_valid = 1'b1; req_addr = a; req_write = 1'b0; req_mode = 2'd1;
    w = 0;
    while (!req_ready) begin
      chk(!(dram_ras && dram_cas), "R11", "no access during refresh", dram_cas, 0);
      @(negedge clk);
      w++;
    end
    chk(w == 5, "R11", "wait for refresh", w, 5);
    chk(ref_cnt == r0 + 1, "R11", "refresh served first", ref_cnt, r0 + 1);
    @(posedge clk);
    follow(a, 1'b0, 8'h00, 2, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_read({12'h123, 9'h045}, 2'd0, "R4");
    t_read({12'h0F0, 9'h100}, 2'd1, "R5");
    t_read({12'hFFF, 9'h000}, 2'd2, "R5");
    t_read({12'h555, 9'h0A3}, 2'd3, "R5");
    t_read({12'h2A7, 9'h1FE}, 2'd2, "R6");
    t_write_back();
    t_refresh();
    t_priority();
    t_read({12'h001, 9'h1FF}, 2'd3, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule